// File: doc/BRIEF.md
# Gated Retriggerable Down-Counter Channel

This block is one channel of a bank of identical counter/timers, used for interval timing and for counting events. A 16-bit count register is loaded from a programmable reload value when the external start input rises, then steps down by one on every clock in which counting is enabled. When the count steps down from one, the channel emits a single-cycle terminal pulse and raises a sticky interrupt request. Software then acknowledges the request with a register write.

The external start and enable inputs are asynchronous. Each passes through a synchronizer before it is used. An optional gate lets the enable input pause counting without losing the count. A control bit sets what happens to a start edge that arrives during a count: it can restart the sequence, or it can be dropped. A second control bit chooses between stopping at zero and reloading for continuous periodic operation. The register port is half the count width. The current count is therefore read in two halves, and reading the low half freezes the high half so that the two halves always belong together.

Top module: `gtc_chan`

## Requirements
- R1: After reset the count is 0, the channel is idle (status bit 1 = 0), `irq` is 0 and `tc_pulse` is 0.
- R2: A rising edge on `trig_in` is seen three clock edges after it is applied: two synchronizer stages plus the edge detect. At that edge the count takes the reload value R and the channel starts running. With a reload value R, the count then falls by one per enabled clock, and `tc_pulse` is high for the single cycle that follows the step down from 1, which is R enabled clocks after the load.
- R3: With control bit 1 (auto-reload) clear, the terminal step leaves the count at 0 and the channel idle.
- R4: With control bit 1 set, the terminal step reloads the count with R and the channel keeps running, so `tc_pulse` repeats every R enabled clocks. If the bit is cleared during a count, the channel stops at the next terminal step.
- R5: With control bit 0 (retrigger) set, a start edge during a count reloads R and restarts the sequence. A start edge that falls on the terminal step takes precedence, so no terminal pulse is produced for that step.
- R6: With control bit 0 clear, a start edge during a count has no effect on the count. This includes a start edge that falls on the terminal step: the channel finishes that count and goes idle.
- R7: With control bit 2 (gate use) set, a low synchronized `gate_in` holds the count unchanged, and a high one lets it count. A change on `gate_in` takes effect on the count at the third clock edge after it is applied. With bit 2 clear, `gate_in` is ignored. A start edge loads the count whatever the gate level.
- R8: A terminal step sets the interrupt-pending flag, seen on `irq` and as status bit 0. The flag stays set until a write to address 3 with data bit 0 = 1 clears it. If the terminal step and the clearing write fall on the same clock, the flag stays set.
- R9: A read of address 4 returns the low half of the count and captures the high half. A later read of address 5 returns that captured high half, even if the count has moved on since.
- R10: Register map, with reads combinational while `rd_en` is high: address 0 holds the low half of the reload value and address 1 its high half (both read/write). Address 2 holds the control bits [2:0] (read/write). Address 3 reads {running, pending} in bits [1:0]. Unused addresses and unused bits read 0, and `rdata` is 0 when `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| gate_in | input | 1 | Asynchronous count enable |
| trig_in | input | 1 | Asynchronous start input, acts on its rising edge |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two pairs of events can fall on the same clock edge: a start edge can coincide with the terminal step, and a clearing write can coincide with the terminal step. The bench times a second start pulse so that its edge detect arrives exactly on the edge where the count would step from 1. It does this once in retrigger mode, where it expects the pulse to be suppressed and a new full period to follow, and once in drop mode, where it expects the pulse and then an idle channel. It also places an acknowledge write on the terminal edge and requires `irq` to remain high. A scoreboard holds the cycle number of every expected terminal pulse, and it flags any pulse that comes early, comes late, is missing or was not expected.

// File: rtl/gtc_pkg.sv
`timescale 1ns/1ps
package gtc_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd5;

    localparam int CTL_W = 3;

    // bit 0 retrigger, bit 1 auto-reload, bit 2 gate use
    typedef struct packed {
        logic gate_use;
        logic auto_rl;
        logic retrig;
    } gtc_ctrl_t;
endpackage

// File: rtl/gtc_sync.sv
`timescale 1ns/1ps
module gtc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gtc_regs.sv
`timescale 1ns/1ps
module gtc_regs
    import gtc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int BUS_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              running,
    input  logic              pend,
    output logic [CNT_W-1:0]  reload,
    output gtc_ctrl_t         ctrl,
    output logic              pend_clr
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        gtc_ctrl_t        ctrl;
        logic [BUS_W-1:0] snap;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                A_RLD_LO: regs_d.reload[BUS_W-1:0]     = wdata;
                A_RLD_HI: regs_d.reload[CNT_W-1:BUS_W] = wdata;
                A_CTRL:   regs_d.ctrl = gtc_ctrl_t'(wdata[CTL_W-1:0]);
                default:  ;
            endcase
        end
        if (rd_en && addr == A_CNT_LO) begin
            regs_d.snap = count[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        pend_clr = wr_en && (addr == A_STAT) && wdata[0];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                A_RLD_LO: rdata = regs_q.reload[BUS_W-1:0];
                A_RLD_HI: rdata = regs_q.reload[CNT_W-1:BUS_W];
                A_CTRL:   rdata = BUS_W'(regs_q.ctrl);
                A_STAT:   rdata = BUS_W'({running, pend});
                A_CNT_LO: rdata = count[BUS_W-1:0];
                A_CNT_HI: rdata = regs_q.snap;
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign reload = regs_q.reload;
    assign ctrl   = regs_q.ctrl;
endmodule

// File: rtl/gtc_core.sv
`timescale 1ns/1ps
module gtc_core
    import gtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] reload,
    input  gtc_ctrl_t        ctrl,
    input  logic             gate_s,
    input  logic             trig_s,
    input  logic             pend_clr,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             tc_pulse,
    output logic             pend,
    output logic             trig_edge,
    output logic             cnt_en
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             running;
        logic             trig_prev;
        logic             tc;
        logic             pend;
    } core_t;

    core_t core_d, core_q;
    logic  trig_take;
    logic  at_one;

    always_comb begin
        core_d           = core_q;
        core_d.tc        = 1'b0;
        core_d.trig_prev = trig_s;

        trig_edge = trig_s & ~core_q.trig_prev;
        cnt_en    = core_q.running & (gate_s | ~ctrl.gate_use);
        trig_take = trig_edge & (~core_q.running | ctrl.retrig);
        at_one    = (core_q.count == CNT_W'(1));

        if (trig_take) begin
            core_d.count   = reload;
            core_d.running = 1'b1;
        end else if (cnt_en) begin
            if (at_one) begin
                core_d.tc = 1'b1;
                if (ctrl.auto_rl) begin
                    core_d.count = reload;
                end else begin
                    core_d.count   = '0;
                    core_d.running = 1'b0;
                end
            end else begin
                core_d.count = core_q.count - CNT_W'(1);
            end
        end

        if (core_d.tc) begin
            core_d.pend = 1'b1;
        end else if (pend_clr) begin
            core_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign count    = core_q.count;
    assign running  = core_q.running;
    assign tc_pulse = core_q.tc;
    assign pend     = core_q.pend;
endmodule

// File: rtl/gtc_chan.sv
`timescale 1ns/1ps
module gtc_chan
    import gtc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int BUS_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic              gate_in,
    input  logic              trig_in,
    output logic              tc_pulse,
    output logic              irq
);
    logic [1:0]       sync_v;
    logic             gate_s;
    logic             trig_s;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] reload_w;
    gtc_ctrl_t        ctrl_w;
    logic             running_w;
    logic             pend_w;
    logic             pend_clr_w;
    logic             trig_edge_w;
    logic             cnt_en_w;

    gtc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({gate_in, trig_in}),
        .dout (sync_v)
    );

    assign gate_s = sync_v[1];
    assign trig_s = sync_v[0];

    gtc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .count   (cnt_w),
        .running (running_w),
        .pend    (pend_w),
        .reload  (reload_w),
        .ctrl    (ctrl_w),
        .pend_clr(pend_clr_w)
    );

    gtc_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload_w),
        .ctrl     (ctrl_w),
        .gate_s   (gate_s),
        .trig_s   (trig_s),
        .pend_clr (pend_clr_w),
        .count    (cnt_w),
        .running  (running_w),
        .tc_pulse (tc_pulse),
        .pend     (pend_w),
        .trig_edge(trig_edge_w),
        .cnt_en   (cnt_en_w)
    );

    assign irq = pend_w;
endmodule

// File: rtl/gtc_chan_chk.sv
`timescale 1ns/1ps
module gtc_chan_chk
    import gtc_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int BUS_W = CNT_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BUS_W-1:0]  rdata,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  reload,
    input gtc_ctrl_t         ctrl,
    input logic              running,
    input logic              gate_s,
    input logic              trig_edge,
    input logic              cnt_en,
    input logic              pend_clr,
    input logic              tc_pulse,
    input logic              irq
);
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !(trig_edge && (!running || ctrl.retrig)) && count != CNT_W'(1))
        |=> count == $past(count) - CNT_W'(1)); // R2

    AST_TC_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(running)); // R2

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !$past(ctrl.auto_rl)) |-> (!running && count == '0)); // R3

    AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && $past(ctrl.auto_rl)) |-> (running && count == $past(reload))); // R4

    AST_RETRIG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_edge && ctrl.retrig) |=> (running && count == $past(reload) && !tc_pulse)); // R5

    AST_NONRETRIG_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && trig_edge && !ctrl.retrig && !cnt_en) |=> $stable(count)); // R6

    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && ctrl.gate_use && !gate_s && !trig_edge) |=> $stable(count)); // R7

    AST_TC_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> irq); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr |=> (irq == tc_pulse)); // R8

    AST_SNAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_CNT_LO) |=> ((rd_en && addr == A_CNT_HI)
            ? (rdata == $past(count[CNT_W-1:BUS_W])) : 1'b1)); // R9
endmodule

bind gtc_chan gtc_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .count    (cnt_w),
    .reload   (reload_w),
    .ctrl     (ctrl_w),
    .running  (running_w),
    .gate_s   (gate_s),
    .trig_edge(trig_edge_w),
    .cnt_en   (cnt_en_w),
    .pend_clr (pend_clr_w),
    .tc_pulse (tc_pulse),
    .irq      (irq)
);

// File: tb/gtc_chan_bench.sv
`timescale 1ns/1ps
module gtc_chan_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       gate_in = 1'b0;
    logic       trig_in = 1'b0;
    logic       tc_pulse;
    logic       irq;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    int    exp_cyc[$];
    string exp_tag[$];

    gtc_chan u_gtc_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .gate_in (gate_in),
        .trig_in (trig_in),
        .tc_pulse(tc_pulse),
        .irq     (irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d at cyc=%0d", tag, act, exp, cyc);
        end
    endtask

    // driver side of the scoreboard: expected terminal pulse cycles
    task automatic expect_tc(input int at, input string tag);
        exp_cyc.push_back(at);
        exp_tag.push_back(tag);
    endtask

    // monitor side
    always @(negedge clk) begin
        if (rst_n && tc_pulse) begin
            checks++;
            if (exp_cyc.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected tc_pulse act=%0d exp=none", cyc);
            end else begin
                automatic int    e = exp_cyc.pop_front();
                automatic string t = exp_tag.pop_front();
                if (e != cyc) begin
                    failures++;
                    $display("FAIL %s tc_pulse cycle act=%0d exp=%0d", t, cyc, e);
                end
            end
        end
    end

    // all tasks are entered just after a falling edge
    task automatic wr(input int a, input int v);
        wr_en = 1'b1; addr = a[2:0]; wdata = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        rd_en = 1'b1; addr = a[2:0];
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_trig();
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog expired act=%0d exp=finished", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int v, c0, c1, cg;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4, v); check("R1 count lo", v, 0);
        rd(5, v); check("R1 count hi", v, 0);
        rd(3, v); check("R1 status", v, 0);
        check("R1 irq", irq, 0);
        check("R1 tc", tc_pulse, 0);

        // R10 register map
        wr(0, 8'h0A); wr(1, 0); wr(2, 7);
        rd(0, v); check("R10 reload lo", v, 8'h0A);
        rd(1, v); check("R10 reload hi", v, 0);
        rd(2, v); check("R10 ctrl", v, 7);
        rd(6, v); check("R10 unused addr", v, 0);
        wr(2, 0);

        // R2 / R3 one-shot, gate ignored (R7 bit 2 clear, gate_in low)
        c0 = cyc;
        expect_tc(c0 + 13, "R2");
        pulse_trig();
        wait_until(c0 + 6);
        rd(4, v); check("R2 count mid", v, 7);
        wait_until(c0 + 20);
        rd(3, v); check("R3 idle with pending", v, 1);
        rd(4, v); check("R3 count zero", v, 0);
        check("R8 irq sticky", irq, 1);
        wr(3, 1);
        check("R8 irq cleared", irq, 0);

        // R6 trigger mid-count ignored
        wr(0, 20);
        c0 = cyc;
        expect_tc(c0 + 23, "R6");
        pulse_trig();
        wait_until(c0 + 8);
        pulse_trig();
        wait_until(c0 + 40);
        rd(3, v); check("R6 idle after count", v, 1);
        wr(3, 1);

        // R5 trigger mid-count restarts
        wr(2, 1);
        c0 = cyc;
        pulse_trig();
        wait_until(c0 + 8);
        c1 = cyc;
        expect_tc(c1 + 23, "R5");
        pulse_trig();
        wait_until(c1 + 30);
        wr(3, 1);

        // R5 trigger on the terminal step wins
        wr(0, 10);
        c0 = cyc;
        pulse_trig();
        wait_until(c0 + 10);
        c1 = cyc;
        expect_tc(c1 + 13, "R5");
        pulse_trig();
        wait_until(c1 + 20);
        rd(3, v); check("R5 idle after restart", v, 1);
        wr(3, 1);

        // R6 trigger on the terminal step dropped
        wr(2, 0);
        c0 = cyc;
        expect_tc(c0 + 13, "R6");
        pulse_trig();
        wait_until(c0 + 10);
        pulse_trig();
        wait_until(c0 + 25);
        rd(3, v); check("R6 idle after coincident trigger", v, 1);
        wr(3, 1);

        // R8 clear write on the terminal edge: set wins
        c0 = cyc;
        expect_tc(c0 + 13, "R8");
        pulse_trig();
        wait_until(c0 + 12);
        wr(3, 1);
        check("R8 set wins over clear", irq, 1);
        wr(3, 1);

        // R7 gate holds then releases
        wr(2, 4);
        c0 = cyc;
        pulse_trig();
        wait_until(c0 + 20);
        rd(4, v); check("R7 count held", v, 10);
        cg = cyc;
        gate_in = 1'b1;
        expect_tc(cg + 12, "R7");
        wait_until(cg + 6);
        rd(4, v); check("R7 count after release", v, 6);
        wait_until(cg + 20);
        rd(3, v); check("R7 idle", v, 1);
        gate_in = 1'b0;
        wr(3, 1);

        // R4 auto-reload, then switch off
        wr(2, 2); wr(0, 7);
        c0 = cyc;
        expect_tc(c0 + 10, "R4");
        expect_tc(c0 + 17, "R4");
        expect_tc(c0 + 24, "R4");
        expect_tc(c0 + 31, "R4");
        pulse_trig();
        wait_until(c0 + 25);
        wr(2, 0);
        wait_until(c0 + 40);
        rd(3, v); check("R4 stopped after mode off", v, 1);
        rd(4, v); check("R4 count zero", v, 0);
        wr(3, 1);

        // R9 coherent two-half read
        wr(0, 8'h04); wr(1, 8'h01);
        c0 = cyc;
        expect_tc(c0 + 263, "R9");
        pulse_trig();
        wait_until(c0 + 7);
        rd(4, v); check("R9 count lo", v, 8'h00);
        wait_until(c0 + 17);
        rd(5, v); check("R9 held hi", v, 8'h01);
        wait_until(c0 + 275);

        checks++;
        if (exp_cyc.size() != 0) begin
            failures++;
            $display("FAIL R2 missing tc pulses act=%0d exp=0", exp_cyc.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule